// File: doc/BRIEF.md
# Pixel Colour Field Unpacker

This block turns a raw framebuffer pixel word into three 8-bit colour components. A pixel word of one to four bytes arrives in little-endian order, one per cycle. For each of red, green and blue, the block takes a bit field whose position and width software programs. It then widens that field to 8 bits by repeating its upper bits. The result leaves through a single register stage, with the valid, blank and underrun flags carried beside it.

Each channel also holds a fallback colour. The fallback colour is used when any of the following holds:
- that channel's field width is programmed to zero;
- the pixel is marked as blanking;
- the pixel is marked as an underrun.

Setting the red fallback to 0xFF and the green and blue fallbacks to zero makes underrun pixels show as pure red.

Top module: `pix_channel_unpack`

## Requirements
- R1: After reset, all three colour outputs are zero, the valid, blank and underrun outputs are low, the byte-count code is 0 and every select register is zero.
- R2: A write with `cfg_sel` = 0 loads the byte-count code from `cfg_wdata[4:3]`. The number of pixel bytes is the code plus one. Pixel bits at or above 8×(code+1) read as zero, even where an extraction field reaches them.
- R3: Writes with `cfg_sel` = 1, 2 and 3 load the red, green and blue select registers. Each select register holds the fallback colour in bits [23:16], the field width in bits [11:8] and the field's lowest bit index in bits [4:0].
- R4: A channel whose field width is zero outputs its fallback colour.
- R5: When `pix_blank` is high, every channel outputs its fallback colour.
- R6: When `pix_underrun` is high, every channel outputs its fallback colour. With fallbacks red 0xFF, green 0 and blue 0, the output is pure red.
- R7: A field narrower than 8 bits is left-aligned. The low bits are filled by repeating the field from its most significant bit downward.
- R8: A field wider than 8 bits yields its top 8 bits.
- R9: A field exactly 8 bits wide passes through unchanged.
- R10: The outputs appear one clock after the pixel input. `out_valid`, `out_blank` and `out_underrun` follow the corresponding inputs with the same one-cycle latency.
- R11: When `cfg_we` is low, `cfg_sel` and `cfg_wdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 byte-count code, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word present |
| pix_word | input | 32 | Raw little-endian pixel word |
| pix_blank | input | 1 | Pixel outside active area |
| pix_underrun | input | 1 | Fetch underran for this pixel |
| out_valid | output | 1 | Output pixel valid |
| out_blank | output | 1 | Delayed blank flag |
| out_underrun | output | 1 | Delayed underrun flag |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
The bench builds the block with its defaults: four-byte words and 8-bit colours. This makes every byte-count code reachable, along with fields up to the 4-bit width maximum of 15 placed anywhere in the 32-bit word. It covers 5-6-5 and 8-8-8 layouts, narrow widths that need repetition, and widths above 8 that need clamping. It also places fields that straddle the byte-count cut-off, and checks the fallback under each of its three triggers.

// File: rtl/pix_channel_unpack.sv
module pix_channel_unpack #(
  parameter int MAX_BYTES = 4,
  parameter int COLOR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [31:0]          cfg_wdata,
  input  logic                 pix_valid,
  input  logic [8*MAX_BYTES-1:0] pix_word,
  input  logic                 pix_blank,
  input  logic                 pix_underrun,
  output logic                 out_valid,
  output logic                 out_blank,
  output logic                 out_underrun,
  output logic [COLOR_W-1:0]   out_r,
  output logic [COLOR_W-1:0]   out_g,
  output logic [COLOR_W-1:0]   out_b
);
  localparam int WORD_W = 8 * MAX_BYTES;
  localparam int LSB_W  = $clog2(WORD_W);
  localparam int CNT_W  = 4;

  logic [1:0]         bpp_code;
  logic [COLOR_W-1:0] def_q [3];
  logic [CNT_W-1:0]   cnt_q [3];
  logic [LSB_W-1:0]   lsb_q [3];
  logic [WORD_W-1:0]  masked;
  logic [COLOR_W-1:0] chan  [3];

  always_ff @(posedge clk)
    if (!rst_n)                    bpp_code <= '0;
    else if (cfg_we && cfg_sel == 2'd0) bpp_code <= cfg_wdata[4:3];

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_mask
    assign masked[8*b +: 8] = (b <= int'(bpp_code)) ? pix_word[8*b +: 8] : 8'h00;
  end

  function automatic logic [COLOR_W-1:0] pick(input logic [WORD_W-1:0] w,
                                              input logic [LSB_W-1:0] lsb,
                                              input logic [CNT_W-1:0] cnt);
    logic [WORD_W-1:0]  sh;
    logic [WORD_W-1:0]  top;
    logic [COLOR_W-1:0] res;
    int n, idx;
    sh  = w >> lsb;
    n   = int'(cnt);
    res = '0;
    if (n >= COLOR_W) begin
      top = sh >> (n - COLOR_W);
      res = top[COLOR_W-1:0];
    end else if (n > 0) begin
      for (int i = 0; i < COLOR_W; i++) begin
        idx    = n - 1 - ((COLOR_W - 1 - i) % n);
        res[i] = sh[idx[LSB_W-1:0]];
      end
    end
    return res;
  endfunction

  for (genvar c = 0; c < 3; c++) begin : g_chan
    always_ff @(posedge clk)
      if (!rst_n) begin
        def_q[c] <= '0;
        cnt_q[c] <= '0;
        lsb_q[c] <= '0;
      end else if (cfg_we && cfg_sel == 2'(c + 1)) begin
        def_q[c] <= cfg_wdata[16 +: COLOR_W];
        cnt_q[c] <= cfg_wdata[8 +: CNT_W];
        lsb_q[c] <= cfg_wdata[0 +: LSB_W];
      end
    assign chan[c] = (pix_blank || pix_underrun || cnt_q[c] == '0)
                     ? def_q[c] : pick(masked, lsb_q[c], cnt_q[c]);
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_blank    <= 1'b0;
      out_underrun <= 1'b0;
      out_r        <= '0;
      out_g        <= '0;
      out_b        <= '0;
    end else begin
      out_valid    <= pix_valid;
      out_blank    <= pix_blank;
      out_underrun <= pix_underrun;
      out_r        <= chan[0];
      out_g        <= chan[1];
      out_b        <= chan[2];
    end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  assert_blank_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_blank |=> (out_r == $past(def_q[0]) && out_g == $past(def_q[1]) && out_b == $past(def_q[2])));
  assert_underrun_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_underrun |=> (out_r == $past(def_q[0]) && out_b == $past(def_q[2])));
  assert_zero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[1] == '0) |=> out_g == $past(def_q[1]));
endmodule

// File: tb/pix_channel_unpack_test.sv
module pix_channel_unpack_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic pix_valid = 0, pix_blank = 0, pix_underrun = 0;
  logic [31:0] pix_word = 0;
  logic out_valid, out_blank, out_underrun;
  logic [7:0] out_r, out_g, out_b;
  int n_chk = 0, n_fail = 0;
  int bytes_m = 1;
  int lsb_m [3];
  int cnt_m [3];
  int def_m [3];

  always #4 clk = ~clk;

  pix_channel_unpack uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_word(pix_word), .pix_blank(pix_blank),
    .pix_underrun(pix_underrun), .out_valid(out_valid), .out_blank(out_blank),
    .out_underrun(out_underrun), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int model(logic [31:0] w, int c);
    longint word, field, acc;
    int bits;
    word = 0;
    for (int b = 0; b < bytes_m; b++) word |= longint'(w[8*b +: 8]) << (8*b);
    if (cnt_m[c] == 0) return def_m[c];
    field = (word >> lsb_m[c]) & ((64'd1 << cnt_m[c]) - 1);
    if (cnt_m[c] > 8) return int'((field >> (cnt_m[c] - 8)) & 255);
    acc = 0; bits = 0;
    while (bits < 8) begin acc = (acc << cnt_m[c]) | field; bits += cnt_m[c]; end
    return int'((acc >> (bits - 8)) & 255);
  endfunction

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_fmt(int bytes);
    wr(2'd0, 32'(bytes - 1) << 3); bytes_m = bytes;
  endtask

  task automatic set_ch(int c, int def, int cnt, int lsb);
    wr(2'(c + 1), {8'h0, 8'(def), 4'h0, 4'(cnt), 3'h0, 5'(lsb)});
    def_m[c] = def; cnt_m[c] = cnt; lsb_m[c] = lsb;
  endtask

  task automatic pix(string req, logic [31:0] w, logic bl, logic ur);
    @(negedge clk); pix_valid = 1; pix_word = w; pix_blank = bl; pix_underrun = ur;
    @(negedge clk); pix_valid = 0; pix_blank = 0; pix_underrun = 0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " blank flag"}, int'(out_blank), int'(bl));
    chk({req, " underrun flag"}, int'(out_underrun), int'(ur));
    chk({req, " red"}, int'(out_r), (bl || ur) ? def_m[0] : model(w, 0));
    chk({req, " green"}, int'(out_g), (bl || ur) ? def_m[1] : model(w, 1));
    chk({req, " blue"}, int'(out_b), (bl || ur) ? def_m[2] : model(w, 2));
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 flags", int'(out_blank | out_underrun), 0);
    chk("R1 colour", int'({out_r, out_g, out_b}), 0);
    for (int c = 0; c < 3; c++) begin def_m[c] = 0; cnt_m[c] = 0; lsb_m[c] = 0; end
    bytes_m = 1;
    pix("R1 regs zero", 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_565;
    set_fmt(2); set_ch(0, 0, 5, 11); set_ch(1, 0, 6, 5); set_ch(2, 0, 5, 0);
    pix("R3 R7 565 a", 32'h0000_F81F, 0, 0);
    pix("R3 R7 565 b", 32'h0000_07E0, 0, 0);
    pix("R3 R7 565 c", 32'h1234_A5C3, 0, 0);
    set_ch(1, 0, 1, 3);
    pix("R7 width1", 32'h0000_0008, 0, 0);
  endtask

  task automatic t_888;
    set_fmt(4); set_ch(0, 0, 8, 16); set_ch(1, 0, 8, 8); set_ch(2, 0, 8, 0);
    pix("R9 888 a", 32'h00C3_5A81, 0, 0);
    pix("R9 888 b", 32'hFF12_34FE, 0, 0);
  endtask

  task automatic t_bytes;
    set_fmt(1); set_ch(0, 0, 8, 8); set_ch(1, 0, 8, 4); set_ch(2, 0, 8, 0);
    pix("R2 one byte", 32'hFFFF_FFFF, 0, 0);
    chk("R2 red beyond byte", int'(out_r), 0);
    chk("R2 green straddle", int'(out_g), 8'h0F);
    set_fmt(3); set_ch(0, 0, 8, 20);
    pix("R2 three bytes", 32'hFFFF_FFFF, 0, 0);
    chk("R2 red straddle", int'(out_r), 8'h0F);
  endtask

  task automatic t_wide;
    set_fmt(4); set_ch(0, 0, 12, 4); set_ch(1, 0, 15, 17); set_ch(2, 0, 9, 0);
    pix("R8 wide a", 32'hABCD_1234, 0, 0);
    pix("R8 wide b", 32'h5A5A_F0F0, 0, 0);
  endtask

  task automatic t_zero;
    set_ch(1, 8'h5A, 0, 8);
    pix("R4 zero width", 32'hFFFF_FFFF, 0, 0);
    chk("R4 green default", int'(out_g), 8'h5A);
  endtask

  task automatic t_fallback;
    set_ch(0, 8'hFF, 8, 16); set_ch(1, 0, 8, 8); set_ch(2, 0, 8, 0);
    pix("R6 underrun red", 32'h0012_3456, 0, 1);
    chk("R6 pure red", int'({out_r, out_g, out_b}), 24'hFF0000);
    set_ch(1, 8'h33, 8, 8); set_ch(2, 8'h77, 8, 0);
    pix("R5 blank", 32'h00AB_CDEF, 1, 0);
    pix("R5 R6 both", 32'h00AB_CDEF, 1, 1);
  endtask

  task automatic t_latency;
    @(negedge clk); pix_valid = 0;
    @(negedge clk);
    chk("R10 idle valid low", int'(out_valid), 0);
    @(negedge clk); pix_valid = 1; pix_word = 32'h0001_0203;
    chk("R10 not yet", int'(out_valid), 0);
    @(negedge clk); pix_valid = 0;
    chk("R10 one cycle", int'(out_valid), 1);
    chk("R10 data", int'(out_r), model(32'h0001_0203, 0));
  endtask

  task automatic t_we_low;
    set_fmt(4); set_ch(0, 0, 8, 0);
    @(negedge clk); cfg_we = 0; cfg_sel = 2'd1; cfg_wdata = {8'h0, 8'hEE, 4'h0, 4'd0, 3'h0, 5'd0};
    @(negedge clk); cfg_sel = 2'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    pix("R11 ignored write", 32'h0000_0042, 0, 0);
    chk("R11 red kept", int'(out_r), 8'h42);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_565; t_888; t_bytes; t_wide; t_zero; t_fallback; t_latency; t_we_low;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule